// File: doc/BRIEF.md
# Split Transmit/Receive Interrupt Aggregator

This block collects interrupt causes for a network controller and presents them as two independent interrupt lines, one for the transmit path and one for the receive path. Hardware sources raise single-cycle event pulses on a 32-bit vector. Each pulse sets a sticky bit in a 32-bit cause register. Software reads that register, clears bits by writing ones to it, and controls the lines through a 32-bit mask register on the same simple register port.

The transmit causes occupy the upper half of the cause word and the receive causes occupy the lower half. For each direction, one bit of the cause word holds a summary. The summary is recomputed from a fixed set of three causes whenever anything that affects that direction changes. The summary bit is then gated by the mask bit at its own position to produce the interrupt line. The lines are registered. A soft-clear input empties both registers and drops both lines.

Top module: `irqagg_top`

## Requirements
- R1: After the asynchronous reset, the cause register and the mask register read 0 and both interrupt lines are low.
- R2: An event pulse on bit n sets cause bit n. The bit stays set on later cycles until software clears it. This applies to bits that are not counted in any summary, such as bit 0 and bit 20.
- R3: A write to the cause register (word address 2) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Transmit summary bit 18 is 1 exactly when at least one of cause bits 16, 17 and 19 is set together with its mask bit. It is re-evaluated on every upper-half event, every cause write and every mask write.
- R6: Receive summary bit 10 is 1 exactly when at least one of cause bits 4, 9 and 11 is set together with its mask bit. It is re-evaluated in the same situations on the lower half.
- R7: `irq_tx` equals cause bit 18 AND mask bit 18. It changes on the clock edge that captures the triggering event or write, and is not combinational from the inputs.
- R8: `irq_rx` equals cause bit 10 AND mask bit 10, with the same timing as R7.
- R9: A write to the mask register (word address 1) stores the full 32-bit value. Both summaries and both lines are re-evaluated against the new mask.
- R10: A cycle with `soft_clr` high clears both registers and drives both lines low on the next edge. It overrides any event or write in that cycle.
- R11: Writes to any word address other than 1 and 2 change nothing. Reads from such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of both registers and lines |
| ev_pulse | input | 32 | Single-cycle event pulses, one per cause bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data (write-one-to-clear for the cause register) |
| rd_addr | input | 4 | Word address of the combinational read |
| rd_data | output | 32 | Read data |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |

## Verification
The bench builds the block with its default parameters: a 32-bit word, summary bits at 18 and 10, mask at word 1 and cause register at word 2, all in a 4-bit address space. These defaults bring the unmapped addresses 0 and 3 to 15 within reach, as well as the non-cause bits on both halves. They also expose the case where the summary bit stays set but its own mask bit is off, so the line stays low. One directed test samples a line before and after the capturing edge to show that it is registered.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;

  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;
  localparam int NUM_DIR = 2;
endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
  import irqagg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 1,
  parameter logic [ADDR_W-1:0] CAUSE_ADDR = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output reg_sel_e          wr_sel,
  output reg_sel_e          rd_sel
);
  function automatic reg_sel_e map_addr(input logic [ADDR_W-1:0] a);
    if (a == CAUSE_ADDR) return SEL_CAUSE;
    else if (a == MASK_ADDR) return SEL_MASK;
    else return SEL_NONE;
  endfunction

  always_comb begin
    wr_sel = wr_en ? map_addr(wr_addr) : SEL_NONE;
    rd_sel = map_addr(rd_addr);
  end
endmodule

// File: rtl/irqagg_cause_eval.sv
module irqagg_cause_eval #(
  parameter int W = 32,
  parameter bit UPPER = 1'b0,
  parameter logic [W-1:0] CAUSE_MASK = '0
) (
  input  logic [W-1:0] cause_pre,
  input  logic [W-1:0] mask_nxt,
  input  logic [W-1:0] ev_pulse,
  input  logic         cause_wr,
  input  logic         mask_wr,
  output logic         eval,
  output logic         sum_val
);
  localparam int H = W / 2;
  localparam logic [W-1:0] LOW_HALF = {{(W-H){1'b0}}, {H{1'b1}}};
  localparam logic [W-1:0] HALF_SEL = UPPER ? ~LOW_HALF : LOW_HALF;

  always_comb begin
    eval = cause_wr | mask_wr | (|(ev_pulse & HALF_SEL));
    sum_val = |(cause_pre & mask_nxt & CAUSE_MASK);
  end
endmodule

// File: rtl/irqagg_status.sv
module irqagg_status
  import irqagg_pkg::*;
#(
  parameter int W = 32,
  parameter int TX_SUM_BIT = 18,
  parameter int RX_SUM_BIT = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_clr,
  input  logic [W-1:0]        ev_pulse,
  input  logic                clr_en,
  input  logic [W-1:0]        clr_data,
  input  logic [NUM_DIR-1:0]  sum_eval,
  input  logic [NUM_DIR-1:0]  sum_val,
  output logic [W-1:0]        cause_pre,
  output logic [W-1:0]        cause_nxt,
  output logic [W-1:0]        cause_q
);
  localparam logic [W-1:0] SUM_MASK = (W'(1) << TX_SUM_BIT) | (W'(1) << RX_SUM_BIT);

  logic [W-1:0] clr_vec;

  always_comb begin
    clr_vec = clr_en ? clr_data : '0;
    // events are OR-ed after the clear so that a set wins over a clear
    cause_pre = (cause_q & ~clr_vec) | ev_pulse;
    cause_nxt = cause_pre;
    if (sum_eval[DIR_TX]) cause_nxt[TX_SUM_BIT] = sum_val[DIR_TX];
    if (sum_eval[DIR_RX]) cause_nxt[RX_SUM_BIT] = sum_val[DIR_RX];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (soft_clr) cause_q <= '0;
    else               cause_q <= cause_nxt;
  end

  // R4: a pulsed non-summary bit is set after the edge, whatever the write did
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_clr |=> ((cause_q & $past(ev_pulse & ~SUM_MASK)) == $past(ev_pulse & ~SUM_MASK)));

  // R3: bits written as one without a concurrent pulse are gone
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && clr_en) |=> ((cause_q & $past(clr_data & ~ev_pulse & ~SUM_MASK)) == '0));

  // R2: without a clear, set non-summary bits stay set
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && !clr_en) |=> ((cause_q & $past(cause_q & ~SUM_MASK)) == $past(cause_q & ~SUM_MASK)));
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int W = 32,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 1,
  parameter logic [ADDR_W-1:0] CAUSE_ADDR = 2,
  parameter int TX_SUM_BIT = 18,
  parameter int RX_SUM_BIT = 10,
  parameter logic [W-1:0] TX_CAUSES = (W'(1) << 16) | (W'(1) << 17) | (W'(1) << 19),
  parameter logic [W-1:0] RX_CAUSES = (W'(1) << 4) | (W'(1) << 9) | (W'(1) << 11)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic [W-1:0]      ev_pulse,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  output logic              irq_tx,
  output logic              irq_rx
);
  reg_sel_e wr_sel, rd_sel;
  logic [W-1:0] cause_pre, cause_nxt, cause_q;
  logic [W-1:0] mask_q, mask_nxt;
  logic [NUM_DIR-1:0] sum_eval, sum_val;
  logic [NUM_DIR-1:0] line_q;
  logic cause_wr, mask_wr;

  irqagg_decode #(
    .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR), .CAUSE_ADDR(CAUSE_ADDR)
  ) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  assign cause_wr = (wr_sel == SEL_CAUSE);
  assign mask_wr  = (wr_sel == SEL_MASK);
  assign mask_nxt = mask_wr ? wr_data : mask_q;

  irqagg_status #(
    .W(W), .TX_SUM_BIT(TX_SUM_BIT), .RX_SUM_BIT(RX_SUM_BIT)
  ) u_status (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .ev_pulse(ev_pulse),
    .clr_en(cause_wr), .clr_data(wr_data),
    .sum_eval(sum_eval), .sum_val(sum_val),
    .cause_pre(cause_pre), .cause_nxt(cause_nxt), .cause_q(cause_q)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam bit IS_TX = (d == DIR_TX);
    localparam logic [W-1:0] CMASK = IS_TX ? TX_CAUSES : RX_CAUSES;
    irqagg_cause_eval #(
      .W(W), .UPPER(IS_TX), .CAUSE_MASK(CMASK)
    ) u_eval (
      .cause_pre(cause_pre), .mask_nxt(mask_nxt), .ev_pulse(ev_pulse),
      .cause_wr(cause_wr), .mask_wr(mask_wr),
      .eval(sum_eval[d]), .sum_val(sum_val[d])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      line_q <= '0;
    end else if (soft_clr) begin
      mask_q <= '0;
      line_q <= '0;
    end else begin
      mask_q <= mask_nxt;
      line_q[DIR_TX] <= cause_nxt[TX_SUM_BIT] & mask_nxt[TX_SUM_BIT];
      line_q[DIR_RX] <= cause_nxt[RX_SUM_BIT] & mask_nxt[RX_SUM_BIT];
    end
  end

  assign irq_tx = line_q[DIR_TX];
  assign irq_rx = line_q[DIR_RX];

  always_comb begin
    unique case (rd_sel)
      SEL_CAUSE: rd_data = cause_q;
      SEL_MASK:  rd_data = mask_q;
      default:   rd_data = '0;
    endcase
  end

  // R5: stored transmit summary agrees with stored causes and mask
  a_r5_tx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[TX_SUM_BIT] == (|(cause_q & mask_q & TX_CAUSES)));
  // R6: same for receive
  a_r6_rx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[RX_SUM_BIT] == (|(cause_q & mask_q & RX_CAUSES)));
  // R7 / R8: each line matches its stored summary gated by its mask bit
  a_r7_tx_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx == (cause_q[TX_SUM_BIT] & mask_q[TX_SUM_BIT]));
  a_r8_rx_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx == (cause_q[RX_SUM_BIT] & mask_q[RX_SUM_BIT]));
  // R10: soft clear empties everything on the next edge
  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (cause_q == '0 && mask_q == '0 && !irq_tx && !irq_rx));
endmodule

// File: tb/tb_irqagg_top.sv
`timescale 1ns/1ps
module tb_irqagg_top;
  localparam int W = 32;
  localparam logic [3:0] A_MASK = 4'h1;
  localparam logic [3:0] A_CAUSE = 4'h2;
  localparam int N = 18;
  // {soft, we, addr, wdata, ev, exp_cause, exp_tx, exp_rx}
  localparam logic [103:0] TBL [0:N-1] = '{
    {1'b0,1'b0,4'h0,32'h0,        32'h00010000, 32'h00010000, 1'b0,1'b0}, // R2
    {1'b0,1'b1,A_MASK,32'h00050000,32'h0,       32'h00050000, 1'b1,1'b0}, // R9
    {1'b0,1'b0,4'h0,32'h0,        32'h00000010, 32'h00050010, 1'b1,1'b0}, // R6
    {1'b0,1'b1,A_MASK,32'h00050410,32'h0,       32'h00050410, 1'b1,1'b1}, // R8
    {1'b0,1'b1,A_CAUSE,32'h00010000,32'h0,      32'h00000410, 1'b0,1'b1}, // R3
    {1'b0,1'b1,A_CAUSE,32'h00000010,32'h00000010,32'h00000410,1'b0,1'b1}, // R4
    {1'b0,1'b1,A_MASK,32'h00050000,32'h0,       32'h00000010, 1'b0,1'b0}, // R9
    {1'b0,1'b0,4'h0,32'h0,        32'h00100001, 32'h00100011, 1'b0,1'b0}, // R2
    {1'b0,1'b0,4'h0,32'h0,        32'h00080000, 32'h00180011, 1'b0,1'b0}, // R5
    {1'b0,1'b1,A_MASK,32'h000D0000,32'h0,       32'h001C0011, 1'b1,1'b0}, // R5
    {1'b0,1'b1,A_MASK,32'h00090000,32'h0,       32'h001C0011, 1'b0,1'b0}, // R7
    {1'b0,1'b1,4'h7,32'hFFFFFFFF, 32'h0,        32'h001C0011, 1'b0,1'b0}, // R11
    {1'b1,1'b1,A_MASK,32'hFFFFFFFF,32'h00000800,32'h0,        1'b0,1'b0}, // R10
    {1'b0,1'b0,4'h0,32'h0,        32'h00000200, 32'h00000200, 1'b0,1'b0}, // R2
    {1'b0,1'b1,A_MASK,32'h00000600,32'h0,       32'h00000600, 1'b0,1'b1}, // R6
    {1'b0,1'b1,A_CAUSE,32'h00000400,32'h0,      32'h00000600, 1'b0,1'b1}, // R6
    {1'b0,1'b1,A_CAUSE,32'hFFFFFFFF,32'h0,      32'h0,        1'b0,1'b0}, // R3
    {1'b0,1'b0,4'h0,32'h0,        32'h00000800, 32'h00000800, 1'b0,1'b0}  // R6
  };

  function automatic string row_req(input int i);
    case (i)
      0, 7, 13: return "R2";
      1, 6: return "R9";
      2, 14, 15, 17: return "R6";
      3: return "R8";
      4, 16: return "R3";
      5: return "R4";
      8, 9: return "R5";
      10: return "R7";
      11: return "R11";
      default: return "R10";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_clr = 1'b0;
  logic [W-1:0] ev_pulse = '0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [3:0] rd_addr = A_CAUSE;
  logic [W-1:0] rd_data;
  logic irq_tx, irq_rx;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqagg_top dut (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .ev_pulse(ev_pulse),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    soft_clr = 1'b0; wr_en = 1'b0; ev_pulse = '0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    rd_addr = A_CAUSE; #1 check("R1 cause", rd_data, 32'h0);
    rd_addr = A_MASK;  #1 check("R1 mask", rd_data, 32'h0);
    check("R1 lines", {30'h0, irq_tx, irq_rx}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    rd_addr = A_CAUSE;

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      soft_clr = TBL[i][103];
      wr_en    = TBL[i][102];
      wr_addr  = TBL[i][101:98];
      wr_data  = TBL[i][97:66];
      ev_pulse = TBL[i][65:34];
      @(posedge clk);
      #1 idle();
      #1;
      check({row_req(i), " cause row"}, rd_data, TBL[i][33:2]);
      check({row_req(i), " lines row"}, {30'h0, irq_tx, irq_rx}, {30'h0, TBL[i][1:0]});
    end

    // R7: line is registered, rises only at the capturing edge
    @(negedge clk); wr_en = 1'b1; wr_addr = A_MASK; wr_data = 32'h00060000;
    @(posedge clk); #1 idle();
    @(negedge clk); ev_pulse = 32'h00020000;
    #1 check("R7 before edge", {31'h0, irq_tx}, 32'h0);
    @(posedge clk); #1 idle();
    check("R7 after edge", {31'h0, irq_tx}, 32'h1);
    check("R5 summary set", rd_data, 32'h00060800);
    // R3: clearing the cause drops the line
    @(negedge clk); wr_en = 1'b1; wr_addr = A_CAUSE; wr_data = 32'h00020000;
    @(posedge clk); #1 idle();
    check("R3 line falls", {31'h0, irq_tx}, 32'h0);
    check("R3 cause after clear", rd_data, 32'h00000800);
    // R9: mask read-back
    rd_addr = A_MASK; #1 check("R9 mask readback", rd_data, 32'h00060000);
    // R11: unmapped reads are zero
    rd_addr = 4'h9; #1 check("R11 unmapped read", rd_data, 32'h0);
    rd_addr = 4'h0; #1 check("R11 unmapped read 0", rd_data, 32'h0);

    finish_run();
  end
endmodule